// File: doc/BRIEF.md
# Multi-Locality Access Arbiter

This block decides which of five numbered localities currently owns a shared register interface. Every register access carries its locality number in address bits [14:12]. The block holds one owner pointer, which may also be empty. It keeps a request flag, a seize flag and a seized-marker for each locality. It reacts to writes of a per-locality access byte that request ownership, give it up or take it by force. On reads it returns the access byte for the addressed locality.

When ownership moves to a valid locality, the block emits a one-cycle locality-changed event that carries the new owner's number. The interrupt logic next to it consumes this event. A handoff or seize can be decided while a command is executing (`cmd_busy` high). In that case the block does not switch at once. It pulses `abort_req`, remembers the target locality and completes the switch when `abort_done` arrives. Command processing, data buffers and register decoding outside the locality field belong to neighbouring blocks.

Access byte layout, for reads and writes:

| Bit | Meaning |
|-----|---------|
| 7 | register-valid, always reads 1 |
| 5 | active (this locality owns the interface); writing 1 releases it |
| 4 | been-seized; writing 1 clears it |
| 3 | seize; writing 1 requests a forced takeover; always reads 0 |
| 2 | pending (some other locality has its request flag set); read only |
| 1 | request-use |
| 6, 0 | read 0 |

Top module: `loc_arbiter`

## Requirements
- R1: The locality is taken from `wr_addr[14:12]` and `rd_addr[14:12]`. Values 5 to 7 are not localities: writes to them change nothing, and reads return 0x00.
- R2: Writes addressed to locality 4 are ignored entirely. Reads from locality 4 still work.
- R3: A request write (bit 1) from a locality that is not the owner makes it the owner at once if no locality is active. Otherwise the write only sets that locality's request flag. A request write from the owner has no effect, and the owner's request flag always reads 0.
- R4: When the owner writes bit 5, ownership goes to the highest-numbered locality whose request flag is set. If no locality is waiting, no locality is active and no event fires. When a non-owner writes bit 5, the only effect is to clear its own request flag.
- R5: A seize write (bit 3) is accepted only if no locality is active or the writer's number is greater than the owner's. It is rejected if the writer already has a seize pending or any higher-numbered locality has one pending. Acceptance cancels the seize flags of all lower localities. Before any other processing, a seize write has its bit 1 and bit 5 removed from that same write.
- R6: When a seize takes ownership, the old owner loses only its active state, keeps its request flag and gets been-seized set. On an ordinary handoff the old owner loses both its active state and its request flag. The new owner always has its request and seize flags cleared.
- R7: A read returns the byte in the layout above. Bit 3 is always 0, bit 7 is always 1, and bit 2 is 1 when some other locality has its request flag set.
- R8: Writing 1 to bit 4 clears that locality's been-seized flag.
- R9: Whenever the owner changes to a valid locality, `chg_evt` is high for exactly one cycle, alongside the updated owner outputs, with `chg_id` equal to the new owner.
- R10: If `cmd_busy` is high when a handoff or an accepted seize is decided, the following happens. `abort_req` pulses for one cycle. The owner stays unchanged until `abort_done` is sampled high. The switch then completes on that edge. A later decision made before `abort_done` replaces the pending target.
- R11: After reset no locality is active, all flags are clear, every valid locality reads 0x80, and `abort_req` and `chg_evt` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | write strobe for an access byte |
| wr_addr | input | 16 | write address; locality in bits [14:12] |
| wr_data | input | 8 | access byte written |
| rd_addr | input | 16 | read address; locality in bits [14:12] |
| rd_data | output | 8 | access byte of the addressed locality (combinational) |
| cmd_busy | input | 1 | a command is executing |
| abort_done | input | 1 | the running command has been aborted |
| abort_req | output | 1 | one-cycle request to abort the running command |
| own_vld | output | 1 | some locality owns the interface |
| own_id | output | 3 | number of the owning locality |
| chg_evt | output | 1 | one-cycle locality-changed event |
| chg_id | output | 3 | locality that just became owner |

## Verification
A wrong owner pointer or wrong flag state shows up at the ports in one of two ways. It appears at once in the access byte of the next read, through the active, pending and been-seized bits. It also appears on the first write that depends on it: a later release hands off to the wrong locality, or a seize that should be rejected is accepted. The checks therefore follow each write with owner and access-byte samples in the very next cycle. Requester-priority and seize-precedence corner cases are driven while a command is busy, so that a wrong pending target is visible when `abort_done` completes the switch.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
   // positions inside the access byte; software decodes these
   localparam int unsigned AB_REQ    = 1;
   localparam int unsigned AB_PEND   = 2;
   localparam int unsigned AB_SEIZE  = 3;
   localparam int unsigned AB_SEIZED = 4;
   localparam int unsigned AB_ACT    = 5;
   localparam int unsigned AB_REGVLD = 7;
   localparam int unsigned AB_W      = 8;
endpackage

// File: rtl/loc_arb_hi_pick.sv
module loc_arb_hi_pick #(
   parameter int unsigned N  = 5,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (vec[i]) begin
            any = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/loc_arb_seize_gate.sv
module loc_arb_seize_gate #(
   parameter int unsigned N  = 5,
   parameter int unsigned IW = 3
) (
   input  logic [N-1:0]  seize_vec,
   input  logic          own_vld,
   input  logic [IW-1:0] own_id,
   input  logic [IW-1:0] req_id,
   output logic          ok,
   output logic [N-1:0]  keep_mask
);
   logic [N-1:0] higher;
   logic [N-1:0] self_sel;

   for (genvar g = 0; g < N; g++) begin : g_loc
      assign higher[g]    = (IW'(g) > req_id);
      assign self_sel[g]  = (IW'(g) == req_id);
      assign keep_mask[g] = !(IW'(g) < req_id);
   end

   assign ok = (!own_vld || (req_id > own_id))
             && !(|(seize_vec & self_sel))
             && !(|(seize_vec & higher));
endmodule

// File: rtl/loc_arb_rd_view.sv
module loc_arb_rd_view
   import loc_arb_pkg::*;
#(
   parameter int unsigned N  = 5,
   parameter int unsigned IW = 3
) (
   input  logic [IW-1:0]   rd_loc,
   input  logic [N-1:0]    req,
   input  logic [N-1:0]    seized,
   input  logic            own_vld,
   input  logic [IW-1:0]   own_id,
   output logic [AB_W-1:0] byte_o
);
   logic [N-1:0] sel;
   logic         loc_ok;

   for (genvar g = 0; g < N; g++) begin : g_sel
      assign sel[g] = (IW'(g) == rd_loc);
   end
   assign loc_ok = |sel;

   always_comb begin
      byte_o = '0;
      if (loc_ok) begin
         byte_o[AB_REGVLD] = 1'b1;
         byte_o[AB_ACT]    = own_vld && (own_id == rd_loc);
         byte_o[AB_SEIZED] = |(seized & sel);
         byte_o[AB_REQ]    = |(req & sel);
         byte_o[AB_PEND]   = |(req & ~sel);
      end
   end
endmodule

// File: rtl/loc_arbiter.sv
module loc_arbiter
   import loc_arb_pkg::*;
#(
   parameter int unsigned NUM_LOC = 5,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LOC_LSB = 12,
   parameter int unsigned LOC_W   = 3,
   parameter int unsigned RO_LOC  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [AB_W-1:0]   wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [AB_W-1:0]   rd_data,
   input  logic              cmd_busy,
   input  logic              abort_done,
   output logic              abort_req,
   output logic              own_vld,
   output logic [LOC_W-1:0]  own_id,
   output logic              chg_evt,
   output logic [LOC_W-1:0]  chg_id
);
   localparam int unsigned LW1 = LOC_W + 1;

   if (LOC_LSB + LOC_W > ADDR_W) begin : g_bad_field
      $error("locality field does not fit in the address");
   end
   if (NUM_LOC < 2 || NUM_LOC > (1 << LOC_W)) begin : g_bad_count
      $error("locality count does not match the field width");
   end

   logic [NUM_LOC-1:0] req_q, req_d, seize_q, seize_d, seized_q, seized_d;
   logic               own_vld_q, own_vld_d, pend_q, pend_d;
   logic [LOC_W-1:0]   own_id_q, own_id_d, tgt_q, tgt_d, evt_id_q, evt_id_d;
   logic               abort_q, abort_d, evt_q, evt_d;

   logic [LOC_W-1:0]   wr_loc, rd_loc;
   logic               wr_ok, wr_is_owner;
   logic               rq_any, sz_ok;
   logic [LOC_W-1:0]   rq_top;
   logic [NUM_LOC-1:0] sz_keep;

   logic [AB_W-1:0]    wv;
   logic               dec, rel_none, sw_go, change;
   logic [LOC_W-1:0]   dec_tgt, sw_tgt;

   assign wr_loc      = wr_addr[LOC_LSB +: LOC_W];
   assign rd_loc      = rd_addr[LOC_LSB +: LOC_W];
   assign wr_ok       = wr_en && ({1'b0, wr_loc} < LW1'(NUM_LOC))
                              && ({1'b0, wr_loc} != LW1'(RO_LOC));
   assign wr_is_owner = own_vld_q && (own_id_q == wr_loc);

   loc_arb_hi_pick #(.N(NUM_LOC), .IW(LOC_W)) i_hi_pick (
      .vec (req_q),
      .any (rq_any),
      .idx (rq_top)
   );

   loc_arb_seize_gate #(.N(NUM_LOC), .IW(LOC_W)) i_seize_gate (
      .seize_vec (seize_q),
      .own_vld   (own_vld_q),
      .own_id    (own_id_q),
      .req_id    (wr_loc),
      .ok        (sz_ok),
      .keep_mask (sz_keep)
   );

   loc_arb_rd_view #(.N(NUM_LOC), .IW(LOC_W)) i_rd_view (
      .rd_loc  (rd_loc),
      .req     (req_q),
      .seized  (seized_q),
      .own_vld (own_vld_q),
      .own_id  (own_id_q),
      .byte_o  (rd_data)
   );

   always_comb begin
      req_d     = req_q;
      seize_d   = seize_q;
      seized_d  = seized_q;
      own_vld_d = own_vld_q;
      own_id_d  = own_id_q;
      pend_d    = pend_q;
      tgt_d     = tgt_q;
      abort_d   = 1'b0;
      evt_d     = 1'b0;
      evt_id_d  = evt_id_q;
      wv        = wr_data;
      dec       = 1'b0;
      dec_tgt   = '0;
      rel_none  = 1'b0;
      sw_go     = 1'b0;
      sw_tgt    = '0;
      change    = 1'b0;

      if (wr_ok) begin
         // a forced takeover cannot also request or release
         if (wv[AB_SEIZE]) begin
            wv[AB_REQ] = 1'b0;
            wv[AB_ACT] = 1'b0;
         end
         if (wv[AB_ACT]) begin
            if (wr_is_owner) begin
               if (rq_any) begin
                  dec     = 1'b1;
                  dec_tgt = rq_top;
               end else begin
                  rel_none = 1'b1;
               end
            end else begin
               req_d[wr_loc] = 1'b0;
            end
         end
         if (wv[AB_SEIZED]) seized_d[wr_loc] = 1'b0;
         if (wv[AB_SEIZE] && sz_ok) begin
            seize_d         = seize_d & sz_keep;
            seize_d[wr_loc] = 1'b1;
            dec             = 1'b1;
            dec_tgt         = wr_loc;
         end
         if (wv[AB_REQ] && !wr_is_owner) begin
            if (own_vld_q) begin
               req_d[wr_loc] = 1'b1;
            end else begin
               sw_go  = 1'b1;
               sw_tgt = wr_loc;
            end
         end
      end

      if (rel_none) begin
         own_vld_d = 1'b0;
         pend_d    = 1'b0;
      end

      if (dec) begin
         if (cmd_busy) begin
            pend_d  = 1'b1;
            tgt_d   = dec_tgt;
            abort_d = 1'b1;
         end else begin
            pend_d = 1'b0;
            sw_go  = 1'b1;
            sw_tgt = dec_tgt;
         end
      end

      if (pend_q && abort_done && !dec && !rel_none && !sw_go) begin
         pend_d = 1'b0;
         sw_go  = 1'b1;
         sw_tgt = tgt_q;
      end

      if (sw_go) begin
         change = !own_vld_q || (own_id_q != sw_tgt);
         if (change && own_vld_q) begin
            if (seize_d[sw_tgt]) seized_d[own_id_q] = 1'b1;
            else                 req_d[own_id_q]    = 1'b0;
         end
         own_vld_d       = 1'b1;
         own_id_d        = sw_tgt;
         req_d[sw_tgt]   = 1'b0;
         seize_d[sw_tgt] = 1'b0;
         if (change) begin
            evt_d    = 1'b1;
            evt_id_d = sw_tgt;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q     <= '0;
         seize_q   <= '0;
         seized_q  <= '0;
         own_vld_q <= 1'b0;
         own_id_q  <= '0;
         pend_q    <= 1'b0;
         tgt_q     <= '0;
         abort_q   <= 1'b0;
         evt_q     <= 1'b0;
         evt_id_q  <= '0;
      end else begin
         req_q     <= req_d;
         seize_q   <= seize_d;
         seized_q  <= seized_d;
         own_vld_q <= own_vld_d;
         own_id_q  <= own_id_d;
         pend_q    <= pend_d;
         tgt_q     <= tgt_d;
         abort_q   <= abort_d;
         evt_q     <= evt_d;
         evt_id_q  <= evt_id_d;
      end
   end

   assign abort_req = abort_q;
   assign own_vld   = own_vld_q;
   assign own_id    = own_id_q;
   assign chg_evt   = evt_q;
   assign chg_id    = evt_id_q;
endmodule

// File: rtl/loc_arb_chk.sv
module loc_arb_chk
   import loc_arb_pkg::*;
#(
   parameter int unsigned NUM_LOC = 5,
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned LOC_LSB = 12,
   parameter int unsigned LOC_W   = 3,
   parameter int unsigned RO_LOC  = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [ADDR_W-1:0]  wr_addr,
   input logic [ADDR_W-1:0]  rd_addr,
   input logic [AB_W-1:0]    rd_data,
   input logic               abort_done,
   input logic               abort_req,
   input logic               own_vld,
   input logic [LOC_W-1:0]   own_id,
   input logic               chg_evt,
   input logic [LOC_W-1:0]   chg_id,
   input logic [NUM_LOC-1:0] req,
   input logic [NUM_LOC-1:0] seized,
   input logic               pend
);
   logic wr_ro, rd_ok;
   assign wr_ro = wr_en && ({1'b0, wr_addr[LOC_LSB +: LOC_W]} == (LOC_W+1)'(RO_LOC));
   assign rd_ok = {1'b0, rd_addr[LOC_LSB +: LOC_W]} < (LOC_W+1)'(NUM_LOC);

   p_ro_loc_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ro && !(pend && abort_done) |=>
         $stable(own_vld) && $stable(own_id) && $stable(req) && $stable(seized));

   p_owner_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
      own_vld |-> !req[own_id]);

   p_seize_hidden_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[AB_SEIZE]);

   p_regvld_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ok |-> rd_data[AB_REGVLD]);

   p_evt_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chg_evt |-> own_vld && (own_id == chg_id));

   p_abort_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort_req |-> pend);

   p_pend_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      pend && !abort_done && !wr_en |=> $stable(own_vld) && $stable(own_id));
endmodule

bind loc_arbiter loc_arb_chk #(
   .NUM_LOC (NUM_LOC),
   .ADDR_W  (ADDR_W),
   .LOC_LSB (LOC_LSB),
   .LOC_W   (LOC_W),
   .RO_LOC  (RO_LOC)
) i_loc_arb_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .abort_done (abort_done),
   .abort_req  (abort_req),
   .own_vld    (own_vld),
   .own_id     (own_id),
   .chg_evt    (chg_evt),
   .chg_id     (chg_id),
   .req        (req_q),
   .seized     (seized_q),
   .pend       (pend_q)
);

// File: tb/test_loc_arbiter.sv
`timescale 1ns/100ps
module test_loc_arbiter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [15:0] rd_addr = '0;
   logic [7:0]  rd_data;
   logic        cmd_busy = 1'b0;
   logic        abort_done = 1'b0;
   logic        abort_req, own_vld, chg_evt;
   logic [2:0]  own_id, chg_id;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   loc_arbiter i_loc_arbiter (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .rd_addr (rd_addr), .rd_data (rd_data),
      .cmd_busy (cmd_busy), .abort_done (abort_done), .abort_req (abort_req),
      .own_vld (own_vld), .own_id (own_id),
      .chg_evt (chg_evt), .chg_id (chg_id)
   );

   // {locality[14:12], write byte[11:4], owner valid[3], owner id[2:0]}
   localparam logic [14:0] VEC [0:13] = '{
      {3'd1, 8'h02, 1'b1, 3'd1},   // R3 no owner: immediate
      {3'd0, 8'h02, 1'b1, 3'd1},   // R3 queue request
      {3'd2, 8'h02, 1'b1, 3'd1},   // R3 queue request
      {3'd1, 8'h20, 1'b1, 3'd2},   // R4 highest requester wins
      {3'd2, 8'h20, 1'b1, 3'd0},   // R4 next requester
      {3'd0, 8'h20, 1'b0, 3'd0},   // R4 nobody waiting
      {3'd3, 8'h02, 1'b1, 3'd3},   // R3
      {3'd1, 8'h08, 1'b1, 3'd3},   // R5 lower seize rejected
      {3'd3, 8'h20, 1'b0, 3'd0},   // R4
      {3'd4, 8'h02, 1'b0, 3'd0},   // R2 locality 4 write ignored
      {3'd5, 8'h02, 1'b0, 3'd0},   // R1 locality 5 is not a locality
      {3'd0, 8'h02, 1'b1, 3'd0},   // R3
      {3'd2, 8'h0A, 1'b1, 3'd2},   // R5 seize with stripped request
      {3'd0, 8'h20, 1'b1, 3'd2}    // R4 non-owner release
   };

   function automatic string row_req(int i);
      case (i)
         0, 1, 2, 6, 11: return "R3";
         3, 4, 5, 8, 13: return "R4";
         7, 12:          return "R5";
         9:              return "R2";
         default:        return "R1";
      endcase
   endfunction

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic wr(int loc, logic [7:0] d);
      @(negedge clk);
      wr_addr = 16'(loc << 12);
      wr_data = d;
      wr_en   = 1'b1;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic chk_rd(int loc, logic [7:0] exp, string tag);
      rd_addr = 16'(loc << 12);
      #1;
      chk(rd_data == exp, tag, $sformatf("access byte of locality %0d", loc), rd_data, exp);
   endtask

   task automatic chk_own(bit v, int id, string tag);
      chk(own_vld == v, tag, "owner valid", own_vld, v);
      if (v) chk(own_id == 3'(id), tag, "owner id", own_id, id);
   endtask

   task automatic pulse_done();
      @(negedge clk);
      abort_done = 1'b1;
      @(negedge clk);
      abort_done = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11 reset state
      chk_own(1'b0, 0, "R11");
      chk(abort_req == 1'b0, "R11", "abort_req", abort_req, 0);
      chk(chg_evt == 1'b0, "R11", "chg_evt", chg_evt, 0);
      for (int l = 0; l < 5; l++) chk_rd(l, 8'h80, "R11");
      chk_rd(5, 8'h00, "R1");
      chk_rd(7, 8'h00, "R1");

      // table walk
      for (int i = 0; i < 14; i++) begin
         wr(int'(VEC[i][14:12]), VEC[i][11:4]);
         chk_own(VEC[i][3], int'(VEC[i][2:0]), row_req(i));
      end

      // R6 seize victim marked; R7 byte layout
      chk_rd(0, 8'h90, "R6");
      chk_rd(2, 8'hA0, "R7");
      chk_rd(4, 8'h80, "R2");
      // R8 write-one clears been-seized
      wr(0, 8'h10);
      chk_rd(0, 8'h80, "R8");
      // R7 pending bit, then ordinary handoff (R6) and event (R9)
      wr(1, 8'h02);
      chk_rd(2, 8'hA4, "R7");
      chk_rd(1, 8'h82, "R7");
      wr(2, 8'h20);
      chk(chg_evt == 1'b1, "R9", "chg_evt on handoff", chg_evt, 1);
      chk(chg_id == 3'd1, "R9", "chg_id on handoff", chg_id, 1);
      chk_own(1'b1, 1, "R4");
      chk_rd(2, 8'h80, "R6");
      @(negedge clk);
      chk(chg_evt == 1'b0, "R9", "chg_evt one cycle", chg_evt, 0);

      // R11 reset from a busy state
      do_reset();
      chk_own(1'b0, 0, "R11");
      for (int l = 0; l < 5; l++) chk_rd(l, 8'h80, "R11");

      // R10 deferred switch while a command runs
      wr(1, 8'h02);
      chk(chg_evt == 1'b1 && chg_id == 3'd1, "R9", "event on first grant", {chg_evt, chg_id}, 4'h9);
      cmd_busy = 1'b1;
      wr(2, 8'h08);
      chk(abort_req == 1'b1, "R10", "abort_req on seize", abort_req, 1);
      chk_own(1'b1, 1, "R10");
      @(negedge clk);
      chk(abort_req == 1'b0, "R10", "abort_req one cycle", abort_req, 0);
      wr(3, 8'h08);
      chk(abort_req == 1'b1, "R5", "higher seize re-targets", abort_req, 1);
      wr(3, 8'h08);
      chk(abort_req == 1'b0, "R5", "seize already pending", abort_req, 0);
      wr(2, 8'h08);
      chk(abort_req == 1'b0, "R5", "higher seize pending", abort_req, 0);
      chk_own(1'b1, 1, "R10");
      chk_rd(1, 8'hA0, "R10");
      repeat (3) @(negedge clk);
      chk_own(1'b1, 1, "R10");
      pulse_done();
      chk_own(1'b1, 3, "R10");
      chk(chg_evt == 1'b1 && chg_id == 3'd3, "R9", "event after abort", {chg_evt, chg_id}, 4'hB);
      chk_rd(1, 8'h90, "R6");
      cmd_busy = 1'b0;

      // R4 non-owner release clears its own request only
      wr(1, 8'h02);
      chk_rd(3, 8'hA4, "R4");
      wr(1, 8'h20);
      chk_rd(3, 8'hA0, "R4");
      chk_own(1'b1, 3, "R4");
      // R3 owner request has no effect
      wr(3, 8'h02);
      chk_rd(3, 8'hA0, "R3");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule